// File: doc/BRIEF.md
# Handshake Word Transfer Between Clock Domains

This block carries a multi-bit word from a source clock domain into an unrelated destination clock domain. The data bits are never synchronized. The source holds the word in a register. It then raises a request line, and that line crosses into the destination through a chain of flip-flops. The destination copies the held word into its own register once it sees the request. It then raises an acknowledge line that crosses back the same way. The source keeps the word frozen until that acknowledge arrives.

The protocol is four-phase. Request stays high until acknowledge is seen, and then falls. Acknowledge falls once the destination sees request low. The source stays busy until it sees acknowledge low again.

A parameter turns on a third control line, a receiver-ready flag that runs from destination to source. The flag drops as soon as the destination sees a request. It comes back only after the request has gone low and the acknowledge has been withdrawn, one destination cycle later. The source takes no new word while the flag is low. This mode trades extra latency per word for an explicit readiness indication.

Each domain has its own active-low asynchronous reset. The request and acknowledge lines reset low, and the ready flag resets high.

Top module: `handshake_cdc_xfer`

## Requirements
- R1: While both resets are asserted, srcBusy is 0, dstStrobe is 0 and dstData is all zeros.
- R2: A word on srcData is accepted at a source clock edge where srcLoad is 1 and srcBusy is 0. From the next source cycle, srcBusy is 1 until the handshake for that word has completed.
- R3: srcLoad asserted while srcBusy is 1 is ignored, and no extra word is delivered.
- R4: Every accepted word appears on dstData exactly once, in acceptance order and unchanged. It appears in the cycle dstStrobe is 1, and acknowledge rises together with that strobe.
- R5: dstData keeps its value in every destination cycle that follows a cycle without a capture.
- R6: The request line falls only after the synchronized acknowledge is 1. The held word does not change while request is high.
- R7: In ready mode (USE_READY=1), the ready flag falls in the cycle after the destination sees request. It rises only after request was seen low. The source accepts a word only while the synchronized ready flag is 1.
- R8: Changes on srcData after a word is accepted do not affect the word that is delivered.
- R9: dstStrobe is never 1 in two consecutive destination cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcClk | input | 1 | Source domain clock |
| srcRstN | input | 1 | Source domain asynchronous reset, active low |
| srcLoad | input | 1 | Offer the word on srcData for transfer |
| srcData | input | DATA_W | Word to transfer |
| srcBusy | output | 1 | High while a transfer is in progress or the receiver is not ready |
| dstClk | input | 1 | Destination domain clock |
| dstRstN | input | 1 | Destination domain asynchronous reset, active low |
| dstData | output | DATA_W | Last word received |
| dstStrobe | output | 1 | One-cycle pulse marking a new word on dstData |

## Verification
The embedded properties check the handshake ordering on every cycle:
- request falls only after acknowledge and stays high while acknowledge is absent,
- the held word is frozen under request,
- the ready flag falls and rises in the order R7 gives, and a word is accepted only while ready is seen high,
- the strobe is a single cycle and the destination register changes only on a capture.

End-to-end properties need the bench's scenarios and its queue-based model:
- every accepted word arrives exactly once and in order,
- loads offered while busy are dropped,
- source data that changes during a transfer does not leak into the delivered word.

// File: rtl/hsx_pkg.sv
package hsx_pkg;

  // Strobes from source control to datapath
  typedef struct packed {
    logic load;      // latch srcData into the hold register
  } srcStb_t;

  // Strobes from destination control to datapath
  typedef struct packed {
    logic capture;   // copy hold register into the output register
  } dstStb_t;

  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_ARM  = 2'd1,
    SRC_REQ  = 2'd2,
    SRC_DROP = 2'd3
  } srcState_e;

  typedef enum logic [1:0] {
    DST_IDLE  = 2'd0,
    DST_HOLD  = 2'd1,
    DST_REARM = 2'd2
  } dstState_e;

endpackage

// File: rtl/hsx_sync.sv
module hsx_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[LAST-1:0], din};
  end

  assign dout = chain[LAST];
endmodule

// File: rtl/hsx_src_ctrl.sv
module hsx_src_ctrl
  import hsx_pkg::*;
#(
  parameter bit USE_READY = 1'b1
) (
  input  logic    srcClk,
  input  logic    srcRstN,
  input  logic    srcLoad,
  input  logic    ackSync,
  input  logic    readySync,
  output logic    srcBusy,
  output logic    srcValid,
  output srcStb_t srcStb
);
  srcState_e state, stateNext;
  logic      validNext;
  logic      rdyGate;

  assign rdyGate = USE_READY ? readySync : 1'b1;
  assign srcBusy = (state != SRC_IDLE) || !rdyGate;

  always_comb begin
    stateNext = state;
    validNext = srcValid;
    srcStb    = '0;
    case (state)
      SRC_IDLE: if (srcLoad && rdyGate) begin
        srcStb.load = 1'b1;
        stateNext   = SRC_ARM;
      end
      SRC_ARM: begin
        validNext = 1'b1;
        stateNext = SRC_REQ;
      end
      SRC_REQ: if (ackSync) begin
        validNext = 1'b0;
        stateNext = SRC_DROP;
      end
      SRC_DROP: if (!ackSync) stateNext = SRC_IDLE;
      default: stateNext = SRC_IDLE;
    endcase
  end

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN) begin
      state    <= SRC_IDLE;
      srcValid <= 1'b0;
    end else begin
      state    <= stateNext;
      srcValid <= validNext;
    end
  end

  // R6
  valid_fall_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    $fell(srcValid) |-> $past(ackSync));
  // R6
  valid_hold_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    (srcValid && !ackSync) |=> srcValid);
  // R2
  busy_cover_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    srcValid |-> srcBusy);
  // R7
  ready_gate_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    srcStb.load |-> (readySync || !USE_READY));
endmodule

// File: rtl/hsx_dst_ctrl.sv
module hsx_dst_ctrl
  import hsx_pkg::*;
#(
  parameter bit USE_READY = 1'b1
) (
  input  logic    dstClk,
  input  logic    dstRstN,
  input  logic    validSync,
  output logic    dstAck,
  output logic    dstReady,
  output logic    dstStrobe,
  output dstStb_t dstStb
);
  dstState_e state, stateNext;
  logic      ackNext, readyNext;

  always_comb begin
    stateNext = state;
    ackNext   = dstAck;
    readyNext = dstReady;
    dstStb    = '0;
    case (state)
      DST_IDLE: if (validSync) begin
        dstStb.capture = 1'b1;
        ackNext        = 1'b1;
        readyNext      = 1'b0;
        stateNext      = DST_HOLD;
      end
      DST_HOLD: if (!validSync) begin
        ackNext = 1'b0;
        if (USE_READY) begin
          stateNext = DST_REARM;
        end else begin
          readyNext = 1'b1;
          stateNext = DST_IDLE;
        end
      end
      DST_REARM: begin
        readyNext = 1'b1;
        stateNext = DST_IDLE;
      end
      default: stateNext = DST_IDLE;
    endcase
  end

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) begin
      state     <= DST_IDLE;
      dstAck    <= 1'b0;
      dstReady  <= 1'b1;
      dstStrobe <= 1'b0;
    end else begin
      state     <= stateNext;
      dstAck    <= ackNext;
      dstReady  <= readyNext;
      dstStrobe <= dstStb.capture;
    end
  end

  // R9
  strobe_single_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    dstStrobe |=> !dstStrobe);
  // R4
  ack_with_strobe_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    $rose(dstAck) |-> dstStrobe);
  // R7
  ready_drop_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    (dstReady && validSync) |=> !dstReady);
  // R7
  ready_rise_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    $rose(dstReady) |-> ($past(!validSync) && !dstAck));
endmodule

// File: rtl/hsx_datapath.sv
module hsx_datapath
  import hsx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  srcStb_t           srcStb,
  input  logic [DATA_W-1:0] srcData,
  input  logic              srcValid,
  input  logic              dstClk,
  input  logic              dstRstN,
  input  dstStb_t           dstStb,
  output logic [DATA_W-1:0] dstData
);
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN)         holdReg <= '0;
    else if (srcStb.load) holdReg <= srcData;
  end

  // holdReg is frozen by the handshake whenever this copy happens
  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN)            outReg <= '0;
    else if (dstStb.capture) outReg <= holdReg;
  end

  assign dstData = outReg;

  // R6
  hold_stable_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    srcValid |-> $stable(holdReg));
  // R5
  out_stable_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    $past(!dstStb.capture) |-> $stable(dstData));
endmodule

// File: rtl/handshake_cdc_xfer.sv
module handshake_cdc_xfer
  import hsx_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit USE_READY   = 1'b1
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic              srcLoad,
  input  logic [DATA_W-1:0] srcData,
  output logic              srcBusy,
  input  logic              dstClk,
  input  logic              dstRstN,
  output logic [DATA_W-1:0] dstData,
  output logic              dstStrobe
);
  srcStb_t srcStb;
  dstStb_t dstStb;
  logic    srcValid, validSync;
  logic    dstAck, ackSync;
  logic    dstReady, readySync;

  hsx_src_ctrl #(.USE_READY(USE_READY)) srcCtrl (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcLoad(srcLoad),
    .ackSync(ackSync), .readySync(readySync),
    .srcBusy(srcBusy), .srcValid(srcValid), .srcStb(srcStb)
  );

  hsx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) validXing (
    .clk(dstClk), .rstN(dstRstN), .din(srcValid), .dout(validSync)
  );

  hsx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) ackXing (
    .clk(srcClk), .rstN(srcRstN), .din(dstAck), .dout(ackSync)
  );

  hsx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) readyXing (
    .clk(srcClk), .rstN(srcRstN), .din(dstReady), .dout(readySync)
  );

  hsx_dst_ctrl #(.USE_READY(USE_READY)) dstCtrl (
    .dstClk(dstClk), .dstRstN(dstRstN), .validSync(validSync),
    .dstAck(dstAck), .dstReady(dstReady), .dstStrobe(dstStrobe), .dstStb(dstStb)
  );

  hsx_datapath #(.DATA_W(DATA_W)) datapath (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcStb(srcStb), .srcData(srcData),
    .srcValid(srcValid), .dstClk(dstClk), .dstRstN(dstRstN), .dstStb(dstStb),
    .dstData(dstData)
  );
endmodule

// File: tb/handshake_cdc_xfer_test.sv
`timescale 1ns/100ps
module handshake_cdc_xfer_test;
  localparam int W = 16;

  logic         srcClk = 1'b0, dstClk = 1'b0;
  logic         srcRstN = 1'b1, dstRstN = 1'b1;
  logic         srcLoad = 1'b0;
  logic [W-1:0] srcData = '0;
  logic         srcBusy, dstStrobe;
  logic [W-1:0] dstData;

  always #2   srcClk = ~srcClk;   // 250 MHz
  always #5.4 dstClk = ~dstClk;   // unrelated destination clock

  handshake_cdc_xfer #(.DATA_W(W)) uut (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcLoad(srcLoad), .srcData(srcData),
    .srcBusy(srcBusy), .dstClk(dstClk), .dstRstN(dstRstN),
    .dstData(dstData), .dstStrobe(dstStrobe)
  );

  int           checks = 0, errors = 0;
  int           accepted = 0, delivered = 0;
  bit           done = 1'b0;
  logic [W-1:0] expQ[$];
  logic [W-1:0] lastOut = '0;
  logic [W-1:0] expWord;
  logic         prevStrobe = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Destination-side reference comparison, every destination cycle
  always @(negedge dstClk) begin
    if (dstRstN && !done) begin
      if (dstStrobe) begin
        chk(!prevStrobe, "R9", "strobe two cycles", W'(prevStrobe), '0);
        if (expQ.size() == 0) begin
          chk(1'b0, "R4", "word with nothing pending", dstData, '0);
        end else begin
          expWord = expQ.pop_front();
          chk(dstData == expWord, "R4", "delivered word", dstData, expWord);
          delivered++;
        end
        lastOut = dstData;
      end else begin
        chk(dstData == lastOut, "R5", "output changed without strobe", dstData, lastOut);
      end
      prevStrobe = dstStrobe;
    end
  end

  // Offer one word; optionally keep loading new data while busy
  task automatic sendWord(input logic [W-1:0] w, input int holdExtra);
    @(negedge srcClk);
    srcLoad = 1'b1;
    srcData = w;
    #0.1;
    while (srcBusy) begin
      @(negedge srcClk);
      #0.1;
    end
    expQ.push_back(w);
    accepted++;
    @(negedge srcClk);
    #0.1;
    chk(srcBusy == 1'b1, "R2", "busy after accept", W'(srcBusy), W'(1));
    for (int k = 0; k < holdExtra; k++) begin
      if (!srcBusy) break;
      srcData = W'($urandom);   // R3 / R8: ignored while busy
      @(negedge srcClk);
      #0.1;
    end
    srcLoad = 1'b0;
    srcData = W'($urandom);     // R8: scrambling after accept
  endtask

  task automatic drain();
    while (delivered < accepted) @(negedge srcClk);
    repeat (30) @(negedge dstClk);
  endtask

  initial begin
    #0.2;
    srcRstN = 1'b0;
    dstRstN = 1'b0;
    #1;
    chk(srcBusy == 1'b0, "R1", "busy in reset", W'(srcBusy), '0);
    chk(dstStrobe == 1'b0, "R1", "strobe in reset", W'(dstStrobe), '0);
    chk(dstData == '0, "R1", "data in reset", dstData, '0);
    #9  srcRstN = 1'b1;
    #13 dstRstN = 1'b1;
    repeat (5) @(negedge srcClk);
    chk(srcBusy == 1'b0, "R1", "idle after reset", W'(srcBusy), '0);

    // Single word
    sendWord(16'hA5C3, 0);
    drain();
    chk(lastOut == 16'hA5C3 && delivered == 1, "R4", "single word", lastOut, 16'hA5C3);

    // Corner words
    sendWord(16'h0000, 0);
    sendWord(16'hFFFF, 0);
    sendWord(16'h0000, 0);

    // Back-to-back: each word waits on busy (and ready gating, R7)
    for (int i = 0; i < 60; i++) sendWord(W'($urandom), 0);
    drain();
    chk(delivered == accepted, "R7", "back-to-back count", W'(delivered), W'(accepted));

    // Loads held while busy with changing data (R3, R8)
    for (int i = 0; i < 50; i++) sendWord(W'($urandom), 12);
    drain();
    chk(delivered == accepted, "R3", "no extra words", W'(delivered), W'(accepted));

    // Random gaps and holds
    for (int i = 0; i < 50; i++) begin
      repeat ($urandom_range(0, 7)) @(negedge srcClk);
      sendWord(W'($urandom), int'($urandom_range(0, 20)));
    end
    drain();

    chk(expQ.size() == 0, "R4", "words left pending", W'(expQ.size()), '0);
    chk(delivered == accepted, "R8", "final count", W'(delivered), W'(accepted));
    chk(srcBusy == 1'b0, "R2", "busy released at end", W'(srcBusy), '0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired accepted=%0d delivered=%0d", accepted, delivered);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule